// File: doc/BRIEF.md
# Descriptor-Driven Configuration DMA Engine

This block is a bus-master copy engine that serves a configuration item store. Software prepares a 16-byte descriptor in system memory and then writes that descriptor's 64-bit address into the engine's trigger register. The engine fetches the descriptor one byte at a time. If the descriptor asks for it, the engine reselects the current item. It then either copies bytes of the item into memory or skips over them. When it is done, it writes a status word back over the descriptor's control field.

The item store keeps the selected key and the read offset. The engine talks to it through a select strobe with a key, an advance strobe, and combinational views of the item's validity, length, offset and current byte. Memory is reached through a byte-wide request/grant master port. Reads of the trigger register return a fixed 8-byte identification value, so software can probe for the engine's presence.

Descriptor layout, all fields big-endian: control word at byte offset 0, length at offset 4, destination address at offset 8. Control bits: bit 1 = read, bit 2 = skip, bit 3 = reselect, bits 31:16 = key. Status bit 0 = error.

Top module: `cfg_dma_engine`

## Requirements
- R1: While idle, a 4-byte write (`regSize`=4) at `regAddr`=0 latches the high half of the descriptor address without starting. A 4-byte write at `regAddr`=4 supplies the low half and starts a transfer. An 8-byte write at `regAddr`=0 supplies the whole address and starts. Any other size/offset write starts nothing.
- R2: Starting a transfer clears the latched high half to zero, so a later low-half-only write fetches its descriptor below 4 GiB.
- R3: While `busy` is high, all register writes are ignored, and the running descriptor is unaffected.
- R4: The descriptor is fetched as 16 byte reads at ascending addresses from its base. A fetch beat answered with `memErr` aborts the fetch. Nothing is selected or transferred, and the status is written with bit 0 set.
- R5: If control bit 3 is set, `itemSelStrobe` pulses once with `itemSelKey` = control bits 31:16 before any data is moved. The item store restarts that item at offset 0.
- R6: Read (bit 1) wins over skip (bit 2). With neither set, the length counts as zero, no data access occurs and the status written is zero. Control bit 0 in the fetched descriptor is ignored.
- R7: A read writes one item byte per memory write beat, at ascending destination addresses starting at the descriptor address. Each beat is taken from the current item offset and pulses `itemAdvance`.
- R8: Once the item's bytes are exhausted, or when the selected item is invalid, a read keeps writing zero bytes until the length is used up, without advancing the item.
- R9: A skip advances the item offset by one per remaining item byte and issues no memory writes. Length beyond the item's end is dropped without any memory access.
- R10: A memory error on a data write beat stops the transfer at that beat, leaves the item offset where it was, and sets status bit 0.
- R11: On completion the 32-bit status is written big-endian to descriptor bytes 0..3 (value 0 on success, 1 on error). After that, `busy` falls and `memReq` stays low.
- R12: `regRdata` returns, right-aligned, bytes `regAddr`..`regAddr+regSize-1` of the big-endian 8-byte identification value. Sizes other than 1, 2, 4 or 8, or ranges past byte 7, read as zero.
- R13: A memory request, with its address and direction, stays unchanged until the cycle in which `memGnt` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Byte offset of the register access |
| regSize | input | 4 | Access size in bytes |
| regWdata | input | 64 | Register write data, right-aligned |
| regRdata | output | 64 | Identification value slice, combinational |
| busy | output | 1 | Transfer in progress |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write beat, 0 = read beat |
| memAddr | output | 64 | Byte address of the beat |
| memWdata | output | 8 | Write byte |
| memGnt | input | 1 | Beat completes this cycle |
| memErr | input | 1 | Error response, valid with grant |
| memRdata | input | 8 | Read byte, valid with grant |
| itemSelStrobe | output | 1 | Reselect item, reset its offset |
| itemSelKey | output | 16 | Key for reselect |
| itemAdvance | output | 1 | Advance item offset by one |
| itemValid | input | 1 | Selected item exists |
| itemLen | input | 32 | Selected item length in bytes |
| itemOffset | input | 32 | Current item offset |
| itemByte | input | 8 | Item byte at current offset |

## Verification
The identification slice on `regRdata` is combinational, so it is compared one time unit after the address and size are set. A trigger write lands on the next rising edge, and `busy` is high when the bench samples it at the following falling edge. Every memory beat ends on the rising edge after a falling edge where the bench raises `memGnt`. The scoreboard pops and compares each write beat at that same falling edge, with grants withheld on every third cycle to exercise stalls. After `busy` is seen low at a falling edge, which is one cycle after the last status beat, the bench checks that no expected beat remains and that the item key and offset match its own prediction.

// File: rtl/cfgdma_pkg.sv
package cfgdma_pkg;

  localparam int ADDR_W     = 64;
  localparam int LEN_W      = 32;
  localparam int KEY_W      = 16;
  localparam int DESC_BYTES = 16;
  localparam int IDX_W      = $clog2(DESC_BYTES);
  localparam int STAT_BYTES = 4;

  // byte positions inside the descriptor (big-endian fields)
  localparam int LEN_FIRST  = 4;
  localparam int ADDR_FIRST = 8;

  // indices into the captured flag vector
  localparam int FLAG_RD   = 0;
  localparam int FLAG_SKIP = 1;
  localparam int FLAG_SEL  = 2;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_FETCH,
    PH_SELECT,
    PH_XFER,
    PH_WBACK
  } phase_e;

  typedef enum logic [1:0] {
    WD_ZERO,
    WD_ITEM,
    WD_STATUS
  } wdSel_e;

  typedef struct packed {
    logic   ldHigh;
    logic   trigLow;
    logic   trigFull;
    logic   capByte;
    logic   beatDone;
    logic   skipRest;
    logic   setErr;
    logic   clearLen;
    logic   useDesc;
    wdSel_e wdSel;
  } dpStrobe_t;

endpackage

// File: rtl/cfgdma_datapath.sv
module cfgdma_datapath
  import cfgdma_pkg::*;
#(
  parameter logic [63:0] SIGNATURE = 64'h4346_475F_444D_4131
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [IDX_W-1:0]  idx,
  input  logic [63:0]       regWdata,
  input  logic [2:0]        regAddr,
  input  logic [3:0]        regSize,
  output logic [63:0]       regRdata,
  input  logic [7:0]        memRdata,
  input  logic [7:0]        itemByte,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic [KEY_W-1:0]  selKey,
  output logic [2:0]        ctrlFlags,
  output logic              lenZero,
  output logic              errFlag,
  output logic [ADDR_W-1:0] descBase
);

  localparam int HALF_W = ADDR_W / 2;

  logic [ADDR_W-1:0] latchAddr;
  logic [ADDR_W-1:0] dstAddr;
  logic [LEN_W-1:0]  lenReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchAddr <= '0;
      descBase  <= '0;
      dstAddr   <= '0;
      lenReg    <= '0;
      selKey    <= '0;
      ctrlFlags <= '0;
      errFlag   <= 1'b0;
    end else begin
      if (strobe.ldHigh) latchAddr[ADDR_W-1:HALF_W] <= regWdata[HALF_W-1:0];
      if (strobe.trigLow) descBase <= {latchAddr[ADDR_W-1:HALF_W], regWdata[HALF_W-1:0]};
      if (strobe.trigFull) descBase <= regWdata;
      if (strobe.trigLow || strobe.trigFull) begin
        latchAddr <= '0;
        errFlag   <= 1'b0;
      end
      if (strobe.capByte) begin
        if (idx < IDX_W'(LEN_FIRST)) begin
          case (idx[1:0])
            2'd0:    selKey[KEY_W-1:8] <= memRdata;
            2'd1:    selKey[7:0]       <= memRdata;
            2'd3:    ctrlFlags         <= memRdata[3:1];
            default: ;
          endcase
        end else if (idx < IDX_W'(ADDR_FIRST)) begin
          lenReg <= {lenReg[LEN_W-9:0], memRdata};
        end else begin
          dstAddr <= {dstAddr[ADDR_W-9:0], memRdata};
        end
      end
      if (strobe.clearLen) lenReg <= '0;
      if (strobe.beatDone) begin
        dstAddr <= dstAddr + ADDR_W'(1);
        lenReg  <= lenReg - LEN_W'(1);
      end
      if (strobe.skipRest) begin
        dstAddr <= dstAddr + ADDR_W'(lenReg);
        lenReg  <= '0;
      end
      if (strobe.setErr) errFlag <= 1'b1;
    end
  end

  assign lenZero = (lenReg == '0);
  assign memAddr = strobe.useDesc ? (descBase + ADDR_W'(idx)) : dstAddr;

  always_comb begin
    case (strobe.wdSel)
      WD_ITEM:   memWdata = itemByte;
      WD_STATUS: memWdata = (idx == IDX_W'(STAT_BYTES - 1)) ? {7'd0, errFlag} : 8'd0;
      default:   memWdata = 8'd0;
    endcase
  end

  // identification value, sliced big-endian by offset and size
  always_comb begin
    int unsigned sz;
    int unsigned off;
    logic [63:0] shifted;
    sz       = int'(regSize);
    off      = int'(regAddr);
    shifted  = '0;
    regRdata = '0;
    if ((sz == 1 || sz == 2 || sz == 4 || sz == 8) && (off + sz <= 8)) begin
      shifted = SIGNATURE >> ((8 - off - sz) * 8);
      for (int b = 0; b < 8; b++) begin
        if (b < int'(sz)) regRdata[b*8 +: 8] = shifted[b*8 +: 8];
      end
    end
  end

  p_latch_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.trigLow || strobe.trigFull) |=> (latchAddr == '0));

endmodule

// File: rtl/cfgdma_ctrl.sv
module cfgdma_ctrl
  import cfgdma_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [2:0]       regAddr,
  input  logic [3:0]       regSize,
  input  logic             memGnt,
  input  logic             memErr,
  input  logic [2:0]       ctrlFlags,
  input  logic             lenZero,
  input  logic             itemValid,
  input  logic [LEN_W-1:0] itemLen,
  input  logic [LEN_W-1:0] itemOffset,
  output dpStrobe_t        strobe,
  output logic [IDX_W-1:0] idx,
  output logic             memReq,
  output logic             memWe,
  output logic             busy,
  output logic             itemSelStrobe,
  output logic             itemAdvance
);

  phase_e           phase, phaseNext;
  logic [IDX_W-1:0] idxNext;
  logic             readMode, readModeNext;
  logic             hasData;

  assign hasData = itemValid && (itemOffset < itemLen);
  assign busy    = (phase != PH_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      idx      <= '0;
      readMode <= 1'b0;
    end else begin
      phase    <= phaseNext;
      idx      <= idxNext;
      readMode <= readModeNext;
    end
  end

  always_comb begin
    phaseNext     = phase;
    idxNext       = idx;
    readModeNext  = readMode;
    strobe        = '0;
    strobe.wdSel  = WD_ZERO;
    memReq        = 1'b0;
    memWe         = 1'b0;
    itemSelStrobe = 1'b0;
    itemAdvance   = 1'b0;
    case (phase)
      PH_IDLE: begin
        if (regWrEn) begin
          if (regAddr == 3'd0 && regSize == 4'd4) begin
            strobe.ldHigh = 1'b1;
          end else if (regAddr == 3'd4 && regSize == 4'd4) begin
            strobe.trigLow = 1'b1;
            phaseNext      = PH_FETCH;
            idxNext        = '0;
          end else if (regAddr == 3'd0 && regSize == 4'd8) begin
            strobe.trigFull = 1'b1;
            phaseNext       = PH_FETCH;
            idxNext         = '0;
          end
        end
      end
      PH_FETCH: begin
        memReq         = 1'b1;
        strobe.useDesc = 1'b1;
        if (memGnt) begin
          if (memErr) begin
            strobe.setErr = 1'b1;
            phaseNext     = PH_WBACK;
            idxNext       = '0;
          end else begin
            strobe.capByte = 1'b1;
            if (idx == IDX_W'(DESC_BYTES - 1)) phaseNext = PH_SELECT;
            else idxNext = idx + IDX_W'(1);
          end
        end
      end
      PH_SELECT: begin
        itemSelStrobe = ctrlFlags[FLAG_SEL];
        readModeNext  = ctrlFlags[FLAG_RD];
        if (!ctrlFlags[FLAG_RD] && !ctrlFlags[FLAG_SKIP]) strobe.clearLen = 1'b1;
        phaseNext = PH_XFER;
      end
      PH_XFER: begin
        if (lenZero) begin
          phaseNext = PH_WBACK;
          idxNext   = '0;
        end else if (readMode) begin
          memReq       = 1'b1;
          memWe        = 1'b1;
          strobe.wdSel = hasData ? WD_ITEM : WD_ZERO;
          if (memGnt) begin
            if (memErr) begin
              strobe.setErr = 1'b1;
              phaseNext     = PH_WBACK;
              idxNext       = '0;
            end else begin
              strobe.beatDone = 1'b1;
              itemAdvance     = hasData;
            end
          end
        end else if (hasData) begin
          strobe.beatDone = 1'b1;
          itemAdvance     = 1'b1;
        end else begin
          strobe.skipRest = 1'b1;
        end
      end
      PH_WBACK: begin
        memReq         = 1'b1;
        memWe          = 1'b1;
        strobe.useDesc = 1'b1;
        strobe.wdSel   = WD_STATUS;
        if (memGnt) begin
          if (idx == IDX_W'(STAT_BYTES - 1)) begin
            phaseNext = PH_IDLE;
            idxNext   = '0;
          end else begin
            idxNext = idx + IDX_W'(1);
          end
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  p_req_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memGnt) |=> (memReq && $stable(memWe)));

endmodule

// File: rtl/cfg_dma_engine.sv
module cfg_dma_engine
  import cfgdma_pkg::*;
#(
  parameter logic [63:0] SIGNATURE = 64'h4346_475F_444D_4131
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [3:0]        regSize,
  input  logic [63:0]       regWdata,
  output logic [63:0]       regRdata,
  output logic              busy,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  input  logic              memGnt,
  input  logic              memErr,
  input  logic [7:0]        memRdata,
  output logic              itemSelStrobe,
  output logic [KEY_W-1:0]  itemSelKey,
  output logic              itemAdvance,
  input  logic              itemValid,
  input  logic [LEN_W-1:0]  itemLen,
  input  logic [LEN_W-1:0]  itemOffset,
  input  logic [7:0]        itemByte
);

  dpStrobe_t         strobe;
  logic [IDX_W-1:0]  idx;
  logic [2:0]        ctrlFlags;
  logic              lenZero;
  logic              errFlag;
  logic [ADDR_W-1:0] descBase;

  cfgdma_ctrl ctrl_i (
    .clk           (clk),
    .rstN          (rstN),
    .regWrEn       (regWrEn),
    .regAddr       (regAddr),
    .regSize       (regSize),
    .memGnt        (memGnt),
    .memErr        (memErr),
    .ctrlFlags     (ctrlFlags),
    .lenZero       (lenZero),
    .itemValid     (itemValid),
    .itemLen       (itemLen),
    .itemOffset    (itemOffset),
    .strobe        (strobe),
    .idx           (idx),
    .memReq        (memReq),
    .memWe         (memWe),
    .busy          (busy),
    .itemSelStrobe (itemSelStrobe),
    .itemAdvance   (itemAdvance)
  );

  cfgdma_datapath #(.SIGNATURE(SIGNATURE)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .idx       (idx),
    .regWdata  (regWdata),
    .regAddr   (regAddr),
    .regSize   (regSize),
    .regRdata  (regRdata),
    .memRdata  (memRdata),
    .itemByte  (itemByte),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .selKey    (itemSelKey),
    .ctrlFlags (ctrlFlags),
    .lenZero   (lenZero),
    .errFlag   (errFlag),
    .descBase  (descBase)
  );

  p_addr_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memGnt) |=> $stable(memAddr));

  p_desc_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(descBase));

  p_sel_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    itemSelStrobe |-> !memReq);

  p_adv_beat_r7: assert property (@(posedge clk) disable iff (!rstN)
    (itemAdvance && memReq) |-> (memWe && memGnt && !memErr));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq);

endmodule

// File: tb/cfg_dma_engine_tb_top.sv
module cfg_dma_engine_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] SIG = 64'h4346_475F_444D_4131;
  localparam int NUM_KEYS = 3;

  string sigText = "CFG_DMA1";

  logic        clk;
  logic        rstN;
  logic        regWrEn;
  logic [2:0]  regAddr;
  logic [3:0]  regSize;
  logic [63:0] regWdata;
  logic [63:0] regRdata;
  logic        busy;
  logic        memReq;
  logic        memWe;
  logic [63:0] memAddr;
  logic [7:0]  memWdata;
  logic        memGnt;
  logic        memErr;
  logic [7:0]  memRdata;
  logic        itemSelStrobe;
  logic [15:0] itemSelKey;
  logic        itemAdvance;
  logic        itemValid;
  logic [31:0] itemLen;
  logic [31:0] itemOffset;
  logic [7:0]  itemByte;

  int nChecks = 0;
  int nErrors = 0;

  logic [7:0]  bmem [0:1023];
  bit          errOn = 1'b0;
  int          errLo = 0;
  int          errHi = 0;

  logic [71:0] expQ [$];
  string       expTag [$];

  logic [15:0] curKey;
  logic [31:0] curOff;
  logic [15:0] predKey;
  logic [31:0] predOff;

  bit          fetchArmed = 1'b0;
  logic [63:0] fetchSeen;
  int          gntPhase = 0;
  bit          stallSeen = 1'b0;
  logic [63:0] stallAddr;
  logic        stallWe;

  cfg_dma_engine #(.SIGNATURE(SIG)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regSize(regSize),
    .regWdata(regWdata), .regRdata(regRdata), .busy(busy), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memGnt(memGnt), .memErr(memErr),
    .memRdata(memRdata), .itemSelStrobe(itemSelStrobe), .itemSelKey(itemSelKey),
    .itemAdvance(itemAdvance), .itemValid(itemValid), .itemLen(itemLen),
    .itemOffset(itemOffset), .itemByte(itemByte)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int lenOf(input logic [15:0] key);
    case (key)
      16'd0:   return 5;
      16'd1:   return 3;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] itemVal(input logic [15:0] key, input logic [31:0] off);
    return 8'((int'(key) * 37 + int'(off) * 11 + 5) & 255);
  endfunction

  function automatic bit inWin(input logic [63:0] a);
    int lo;
    lo = int'(a[9:0]);
    return errOn && (lo >= errLo) && (lo < errHi);
  endfunction

  // item store model
  always @(posedge clk) begin
    if (!rstN) begin
      curKey <= '0;
      curOff <= '0;
    end else if (itemSelStrobe) begin
      curKey <= itemSelKey;
      curOff <= '0;
    end else if (itemAdvance) begin
      curOff <= curOff + 32'd1;
    end
  end

  assign itemValid  = (curKey < NUM_KEYS);
  assign itemLen    = 32'(lenOf(curKey));
  assign itemOffset = curOff;
  assign itemByte   = itemVal(curKey, curOff);

  always_comb begin
    memRdata = bmem[memAddr[9:0]];
    memErr   = memGnt && errOn && (int'(memAddr[9:0]) >= errLo) && (int'(memAddr[9:0]) < errHi);
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // grant driver and scoreboard monitor
  always @(negedge clk) begin
    if (!rstN) begin
      memGnt = 1'b0;
    end else begin
      if (stallSeen && memReq) begin
        check((memAddr == stallAddr) && (memWe == stallWe), "R13", "request changed while stalled",
              memAddr, stallAddr);
      end
      gntPhase++;
      memGnt = memReq && ((gntPhase % 3) != 0);
      stallSeen = memReq && !memGnt;
      stallAddr = memAddr;
      stallWe   = memWe;
      if (memGnt && memWe) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R11", "unexpected write beat", {memAddr[55:0], memWdata}, 64'd0);
        end else begin
          logic [71:0] e;
          string t;
          e = expQ.pop_front();
          t = expTag.pop_front();
          check({memAddr, memWdata} == e, t, "write beat addr/data",
                {memAddr[55:0], memWdata}, {e[63:8], e[7:0]});
        end
      end
      if (memGnt && !memWe && fetchArmed) begin
        fetchSeen  = memAddr;
        fetchArmed = 1'b0;
      end
    end
  end

  task automatic push(input logic [63:0] a, input logic [7:0] d, input string tag);
    expQ.push_back({a, d});
    expTag.push_back(tag);
  endtask

  task automatic putDesc(input logic [63:0] base, input logic [31:0] ctrl,
                         input logic [31:0] len, input logic [63:0] dst);
    for (int i = 0; i < 4; i++) begin
      bmem[10'(base + 64'(i))]     = ctrl[31 - 8*i -: 8];
      bmem[10'(base + 64'(4 + i))] = len[31 - 8*i -: 8];
    end
    for (int i = 0; i < 8; i++) bmem[10'(base + 64'(8 + i))] = dst[63 - 8*i -: 8];
  endtask

  // independent prediction of every write beat of one descriptor
  task automatic predict(input string tag, input logic [63:0] base, input logic [31:0] ctrl,
                         input logic [31:0] len, input logic [63:0] dst);
    bit fetchBad;
    bit err;
    bit rd;
    bit sk;
    int n;
    logic [63:0] a;
    fetchBad = 1'b0;
    err = 1'b0;
    for (int i = 0; i < 16; i++) if (inWin(base + 64'(i))) fetchBad = 1'b1;
    if (!fetchBad) begin
      if (ctrl[3]) begin
        predKey = ctrl[31:16];
        predOff = '0;
      end
      rd = ctrl[1];
      sk = !rd && ctrl[2];
      n  = (rd || sk) ? int'(len) : 0;
      a  = dst;
      while (n > 0 && !err) begin
        bit has;
        has = (predKey < NUM_KEYS) && (int'(predOff) < lenOf(predKey));
        if (rd) begin
          push(a, has ? itemVal(predKey, predOff) : 8'd0, tag);
          if (inWin(a)) err = 1'b1;
          else begin
            if (has) predOff = predOff + 1;
            a = a + 1;
            n = n - 1;
          end
        end else if (has) begin
          predOff = predOff + 1;
          n = n - 1;
        end else begin
          n = 0;
        end
      end
    end
    push(base, 8'd0, "R11");
    push(base + 1, 8'd0, "R11");
    push(base + 2, 8'd0, "R11");
    push(base + 3, {7'd0, err | fetchBad}, (err | fetchBad) ? "R10" : "R11");
  endtask

  task automatic regWrite(input logic [2:0] addr, input logic [3:0] size, input logic [63:0] data);
    @(negedge clk);
    regWrEn  = 1'b1;
    regAddr  = addr;
    regSize  = size;
    regWdata = data;
    @(negedge clk);
    regWrEn  = 1'b0;
  endtask

  task automatic finishCase(input string tag);
    int cnt;
    cnt = 0;
    while (busy && cnt < 3000) begin
      @(negedge clk);
      cnt++;
    end
    check(!busy, tag, "transfer did not complete", 64'(busy), 64'd0);
    check(expQ.size() == 0, tag, "expected beats left over", 64'(expQ.size()), 64'd0);
    expQ.delete();
    expTag.delete();
    check(curKey == predKey, tag, "item key", 64'(curKey), 64'(predKey));
    check(curOff == predOff, tag, "item offset", 64'(curOff), 64'(predOff));
  endtask

  task automatic runFull(input string tag, input logic [63:0] base, input logic [31:0] ctrl,
                         input logic [31:0] len, input logic [63:0] dst);
    putDesc(base, ctrl, len, dst);
    predict(tag, base, ctrl, len, dst);
    regWrite(3'd0, 4'd8, base);
    finishCase(tag);
  endtask

  task automatic sigCheck(input int off, input int size);
    logic [63:0] exp;
    @(negedge clk);
    regAddr = 3'(off);
    regSize = 4'(size);
    #1;
    exp = '0;
    if ((size == 1 || size == 2 || size == 4 || size == 8) && off + size <= 8)
      for (int i = 0; i < size; i++) exp = (exp << 8) | 64'(sigText[off + i]);
    check(regRdata == exp, "R12", $sformatf("signature off=%0d size=%0d", off, size), regRdata, exp);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "R11", "watchdog expired", 64'd0, 64'd1);
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) bmem[i] = 8'hEE;
    rstN = 1'b0;
    regWrEn = 1'b0;
    regAddr = '0;
    regSize = '0;
    regWdata = '0;
    predKey = '0;
    predOff = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R11", "busy after reset", 64'(busy), 64'd0);
    check(memReq == 1'b0, "R11", "memReq after reset", 64'(memReq), 64'd0);

    // R12 identification slices
    sigCheck(0, 8);
    sigCheck(0, 4);
    sigCheck(4, 4);
    sigCheck(3, 1);
    sigCheck(6, 2);
    sigCheck(6, 4);

    // R5 R7: reselect key 0, read whole item
    runFull("R7", 64'h100, 32'h0000_000A, 32'd5, 64'h200);
    // R8: key 1 is 3 bytes, read 6 -> zero fill
    runFull("R8", 64'h120, 32'h0001_000A, 32'd6, 64'h240);
    // R8: invalid key
    runFull("R8", 64'h140, 32'h0007_000A, 32'd4, 64'h260);
    // R9: skip 2 inside key 0, then read 2 without reselect, then skip past end
    runFull("R9", 64'h100, 32'h0000_000C, 32'd2, 64'h200);
    runFull("R5", 64'h120, 32'h0000_0002, 32'd2, 64'h280);
    runFull("R9", 64'h140, 32'h0000_0004, 32'd10, 64'h290);
    // R6: read and skip both set -> read
    runFull("R6", 64'h100, 32'h0001_0006, 32'd3, 64'h2C0);
    // R6: neither set, error bit set in descriptor is ignored
    runFull("R6", 64'h120, 32'h0000_0001, 32'd4, 64'h2D0);
    // R10: write error on third data byte
    errOn = 1'b1; errLo = 'h2A2; errHi = 'h2A3;
    runFull("R10", 64'h160, 32'h0000_000A, 32'd5, 64'h2A0);
    // R4: fetch error on descriptor byte 4
    errLo = 'h1C4; errHi = 'h1C8;
    runFull("R4", 64'h1C0, 32'h0001_000A, 32'd3, 64'h2B0);
    errOn = 1'b0;

    // R1: writes that must not start
    regWrite(3'd4, 4'd2, 64'h100);
    regWrite(3'd4, 4'd8, 64'h100);
    regWrite(3'd2, 4'd4, 64'h100);
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1", "non-trigger write started engine", 64'(busy), 64'd0);
    check(memReq == 1'b0, "R1", "non-trigger write made request", 64'(memReq), 64'd0);

    // R1 R2: high half then low half, then low half alone
    putDesc(64'h300, 32'h0000_000A, 32'd2, 64'h320);
    predict("R1", 64'h1_0000_0300, 32'h0000_000A, 32'd2, 64'h320);
    regWrite(3'd0, 4'd4, 64'h1);
    fetchArmed = 1'b1;
    regWrite(3'd4, 4'd4, 64'h300);
    finishCase("R1");
    check(fetchSeen == 64'h1_0000_0300, "R1", "first fetch address", fetchSeen, 64'h1_0000_0300);
    putDesc(64'h340, 32'h0000_0002, 32'd1, 64'h330);
    predict("R2", 64'h340, 32'h0000_0002, 32'd1, 64'h330);
    fetchArmed = 1'b1;
    regWrite(3'd4, 4'd4, 64'h340);
    finishCase("R2");
    check(fetchSeen == 64'h340, "R2", "high half not cleared", fetchSeen, 64'h340);

    // R3: trigger while busy is ignored
    putDesc(64'h380, 32'h0001_000A, 32'd2, 64'h3A0);
    putDesc(64'h3C0, 32'h0000_000A, 32'd4, 64'h3E0);
    predict("R3", 64'h380, 32'h0001_000A, 32'd2, 64'h3A0);
    fetchArmed = 1'b1;
    regWrite(3'd0, 4'd8, 64'h380);
    regWrite(3'd0, 4'd8, 64'h3C0);
    regWrite(3'd4, 4'd4, 64'h3C0);
    finishCase("R3");
    check(fetchSeen == 64'h380, "R3", "first fetch address", fetchSeen, 64'h380);
    repeat (4) @(negedge clk);
    check(busy == 1'b0, "R3", "ignored trigger restarted engine", 64'(busy), 64'd0);

    summary();
    $finish;
  end

endmodule